// File: doc/BRIEF.md
# Sticky Access-Protection Register

This block is an 8-bit special-function register holding a device's protection switches and lifecycle level, together with the gating those switches apply to three resources: a nonvolatile program memory (NVM), a multi-time-programmable memory (MTP) and a debug port. After power-on reset every bit is clear. A boot-load strobe then copies one configuration word into the register. From that point software may write the register over a simple register bus, but a bit can only be set. A zero in the write data leaves the bit as it was. Only the power-on reset returns the bits to zero. The stored configuration word outside the block is never touched by these writes.

The memories and the debug port are modelled as request/response ports. The block passes each request through, or blocks it, according to the current register value. When a read is blocked, its data is forced to zero. When a write is blocked, the memory-side write enable stays low and a one-cycle error flag is raised. The NVM write-protect bit only has an effect when the lifecycle field is at run level.

Top module: `guard_cfg_reg`

## Requirements
- R1: After reset (`rst` high, synchronous) the register reads 0x00 and every request is passed through with its enable high, including `dbg_grant`.
- R2: The first `boot_vld` after reset loads `boot_word` (bit 5 forced to 0), and the new value is visible on the next cycle. A `boot_vld` after that is ignored, and a boot strobe wins over a bus write in the same cycle.
- R3: Bus writes are ignored until the boot load has completed. Bus writes to any address other than 0xDA never change the register.
- R4: A bus write to address 0xDA after boot updates the register to old | (wdata & 0xDF) on the next cycle, so a written 0 never clears a bit.
- R5: Bit 5 is reserved and always reads 0.
- R6: While bit 7 (NVM lock) is set, `nvm_rd_en` and `nvm_wr_en` are 0 and `nvm_rdata` is 0x00. While it is clear, NVM reads pass `nvm_mem_rdata` through in the same cycle.
- R7: Bit 3 (NVM write-protect) blocks NVM writes only when bits [2:1] are both 1 (run level; the level codes are 001 factory, 011 user, 111 run). It has no effect on reads, and no effect at any other level.
- R8: While bit 4 (MTP lock) is set, `mtp_rd_en` and `mtp_wr_en` are 0 and `mtp_rdata` is 0x00.
- R9: While bit 6 (debug off) is set, `dbg_grant` is 0. Otherwise `dbg_grant` follows `dbg_req`.
- R10: A write request that is blocked raises the matching error flag (`nvm_err` or `mtp_err`) for one cycle, on the cycle after the request. A write that is passed through raises no flag.
- R11: A bus read at any address other than 0xDA returns 0x00 on `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| boot_vld | input | 1 | Boot-load strobe |
| boot_word | input | 8 | Configuration word from storage |
| bus_wr | input | 1 | Register bus write strobe |
| bus_addr | input | 8 | Register bus address |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register read data; 0 when the address does not match |
| nvm_rd_req | input | 1 | NVM read request |
| nvm_wr_req | input | 1 | NVM write request |
| nvm_mem_rdata | input | 8 | Data from the NVM |
| nvm_rd_en | output | 1 | Read enable toward the NVM |
| nvm_wr_en | output | 1 | Write enable toward the NVM |
| nvm_rdata | output | 8 | Gated NVM read data |
| nvm_err | output | 1 | Blocked NVM write pulse |
| mtp_rd_req | input | 1 | MTP read request |
| mtp_wr_req | input | 1 | MTP write request |
| mtp_mem_rdata | input | 8 | Data from the MTP |
| mtp_rd_en | output | 1 | Read enable toward the MTP |
| mtp_wr_en | output | 1 | Write enable toward the MTP |
| mtp_rdata | output | 8 | Gated MTP read data |
| mtp_err | output | 1 | Blocked MTP write pulse |
| dbg_req | input | 1 | Debug access request |
| dbg_grant | output | 1 | Debug access granted |

## Verification
The register's results appear at different times. A register update from a boot load or a bus write shows up on `bus_rdata` one clock after the strobe. The enables, the gated read data and `dbg_grant` follow the current register value in the same cycle. The error flags are registered, so they appear one clock after the blocked request and fall on the clock after that. The bench drives inputs just after a rising edge and then samples at these points: the combinational outputs within the same cycle, the register value and the error flags after the next edge, and the falling edge of each error flag one further edge on. Every one of the 256 boot words goes through this sequence.

// File: rtl/guard_pkg.sv
package guard_pkg;
    localparam int DW       = 8;
    localparam int ADDR_W   = 8;
    localparam logic [ADDR_W-1:0] REG_ADDR = 8'hDA;
    localparam logic [DW-1:0]     IMPL_MASK = 8'hDF;

    typedef struct packed {
        logic       nvm_lock;
        logic       dbg_off;
        logic       rsvd;
        logic       mtp_lock;
        logic       nvm_wp;
        logic [2:0] level;
    } prot_t;

    function automatic logic at_run(input logic [2:0] level);
        return level[2] & level[1];
    endfunction
endpackage

// File: rtl/guard_setonly_reg.sv
module guard_setonly_reg
    import guard_pkg::*;
#(
    parameter int W = DW,
    parameter int AW = ADDR_W,
    parameter logic [AW-1:0] ADDR = REG_ADDR,
    parameter logic [W-1:0] MASK = IMPL_MASK
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          boot_vld,
    input  logic [W-1:0]  boot_word,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  q,
    output logic          booted
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            booted <= 1'b0;
        end else if (boot_vld && !booted) begin
            q      <= boot_word & MASK;
            booted <= 1'b1;
        end else if (booted && wr && addr == ADDR) begin
            q <= q | (wdata & MASK);
        end
    end

    // R4: once booted, no bit that was set is ever cleared
    a_r4_no_clear: assert property (@(posedge clk) disable iff (rst)
        booted |=> ((q & $past(q)) == $past(q)));

    // R3: no boot strobe and not yet booted means nothing moves
    a_r3_preboot_hold: assert property (@(posedge clk) disable iff (rst)
        (!booted && !boot_vld) |=> (q == '0));

    // R5: reserved positions stay clear
    a_r5_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        (q & ~MASK) == '0);
endmodule

// File: rtl/guard_mem_gate.sv
module guard_mem_gate
    import guard_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rd_req,
    input  logic         wr_req,
    input  logic         rd_block,
    input  logic         wr_block,
    input  logic [W-1:0] mem_rdata,
    output logic         rd_en,
    output logic         wr_en,
    output logic [W-1:0] rdata,
    output logic         err
);
    always_comb begin
        rd_en = rd_req & ~rd_block;
        wr_en = wr_req & ~wr_block;
        rdata = rd_block ? '0 : mem_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= wr_req & wr_block;
    end

    // R10: a refused write is flagged on the following cycle
    a_r10_err_after_block: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_en) |=> err);

    // R10: a write that went through leaves no flag
    a_r10_no_err_on_pass: assert property (@(posedge clk) disable iff (rst)
        (wr_en) |=> !err);

    // R6/R8: blocked reads never show memory data
    a_r8_zero_when_blocked: assert property (@(posedge clk) disable iff (rst)
        rd_block |-> (rdata == '0 && !rd_en));
endmodule

// File: rtl/guard_cfg_reg.sv
module guard_cfg_reg
    import guard_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        boot_vld,
    input  logic [7:0]  boot_word,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        nvm_rd_req,
    input  logic        nvm_wr_req,
    input  logic [7:0]  nvm_mem_rdata,
    output logic        nvm_rd_en,
    output logic        nvm_wr_en,
    output logic [7:0]  nvm_rdata,
    output logic        nvm_err,
    input  logic        mtp_rd_req,
    input  logic        mtp_wr_req,
    input  logic [7:0]  mtp_mem_rdata,
    output logic        mtp_rd_en,
    output logic        mtp_wr_en,
    output logic [7:0]  mtp_rdata,
    output logic        mtp_err,
    input  logic        dbg_req,
    output logic        dbg_grant
);
    logic [DW-1:0] reg_q;
    logic          booted;
    prot_t         prot;
    logic          nvm_wr_block;

    guard_setonly_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .boot_vld  (boot_vld),
        .boot_word (boot_word),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .q         (reg_q),
        .booted    (booted)
    );

    assign prot         = prot_t'(reg_q);
    assign nvm_wr_block = prot.nvm_lock | (prot.nvm_wp & at_run(prot.level));
    assign bus_rdata    = (bus_addr == REG_ADDR) ? reg_q : '0;
    assign dbg_grant    = dbg_req & ~prot.dbg_off;

    guard_mem_gate u_nvm (
        .clk       (clk),
        .rst       (rst),
        .rd_req    (nvm_rd_req),
        .wr_req    (nvm_wr_req),
        .rd_block  (prot.nvm_lock),
        .wr_block  (nvm_wr_block),
        .mem_rdata (nvm_mem_rdata),
        .rd_en     (nvm_rd_en),
        .wr_en     (nvm_wr_en),
        .rdata     (nvm_rdata),
        .err       (nvm_err)
    );

    guard_mem_gate u_mtp (
        .clk       (clk),
        .rst       (rst),
        .rd_req    (mtp_rd_req),
        .wr_req    (mtp_wr_req),
        .rd_block  (prot.mtp_lock),
        .wr_block  (prot.mtp_lock),
        .mem_rdata (mtp_mem_rdata),
        .rd_en     (mtp_rd_en),
        .wr_en     (mtp_wr_en),
        .rdata     (mtp_rdata),
        .err       (mtp_err)
    );

    // R9: debug refused while the disable bit is set
    a_r9_dbg_refused: assert property (@(posedge clk) disable iff (rst)
        prot.dbg_off |-> !dbg_grant);

    // R7: below run level the write-protect bit never refuses a write
    a_r7_wp_needs_run: assert property (@(posedge clk) disable iff (rst)
        (nvm_wr_req && !prot.nvm_lock && !(prot.level[2] && prot.level[1])) |-> nvm_wr_en);

    // R6: full lock shuts both NVM directions
    a_r6_nvm_locked: assert property (@(posedge clk) disable iff (rst)
        prot.nvm_lock |-> (!nvm_rd_en && !nvm_wr_en));
endmodule

// File: tb/guard_cfg_reg_bench.sv
module guard_cfg_reg_bench;
    localparam time CLK_P = 20ns;

    logic       clk = 1'b0;
    logic       rst;
    logic       boot_vld;
    logic [7:0] boot_word;
    logic       bus_wr;
    logic [7:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       nvm_rd_req, nvm_wr_req;
    logic [7:0] nvm_mem_rdata;
    logic       nvm_rd_en, nvm_wr_en, nvm_err;
    logic [7:0] nvm_rdata;
    logic       mtp_rd_req, mtp_wr_req;
    logic [7:0] mtp_mem_rdata;
    logic       mtp_rd_en, mtp_wr_en, mtp_err;
    logic [7:0] mtp_rdata;
    logic       dbg_req, dbg_grant;

    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    guard_cfg_reg u_guard_cfg_reg (
        .clk(clk), .rst(rst),
        .boot_vld(boot_vld), .boot_word(boot_word),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .nvm_rd_req(nvm_rd_req), .nvm_wr_req(nvm_wr_req), .nvm_mem_rdata(nvm_mem_rdata),
        .nvm_rd_en(nvm_rd_en), .nvm_wr_en(nvm_wr_en), .nvm_rdata(nvm_rdata), .nvm_err(nvm_err),
        .mtp_rd_req(mtp_rd_req), .mtp_wr_req(mtp_wr_req), .mtp_mem_rdata(mtp_mem_rdata),
        .mtp_rd_en(mtp_rd_en), .mtp_wr_en(mtp_wr_en), .mtp_rdata(mtp_rdata), .mtp_err(mtp_err),
        .dbg_req(dbg_req), .dbg_grant(dbg_grant)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        boot_vld = 0; boot_word = 0; bus_wr = 0; bus_addr = 8'hDA; bus_wdata = 0;
        nvm_rd_req = 0; nvm_wr_req = 0; mtp_rd_req = 0; mtp_wr_req = 0; dbg_req = 0;
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        nvm_mem_rdata = 8'hA5;
        mtp_mem_rdata = 8'h5A;
        idle();
        rst = 1;
        for (int b = 0; b < 256; b++) begin
            logic [7:0] e, w;
            logic nlock, mlock, doff, wblk;
            idle();
            rst = 1; tick(); tick(); rst = 0; #1;
            // R1 reset state
            chk("R1 reset read", bus_rdata, 8'h00);
            dbg_req = 1; nvm_rd_req = 1; mtp_rd_req = 1; #1;
            chk("R1 reset dbg", {7'd0, dbg_grant}, 8'h01);
            chk("R1 reset nvm rd", {7'd0, nvm_rd_en}, 8'h01);
            chk("R1 reset mtp rd", mtp_rdata, 8'h5A);
            idle();
            // R3 write before boot ignored
            bus_wr = 1; bus_wdata = 8'hFF; tick(); idle(); #1;
            chk("R3 preboot write", bus_rdata, 8'h00);
            // R2 boot load, bus write in same cycle loses
            boot_vld = 1; boot_word = b[7:0]; bus_wr = 1; bus_wdata = 8'hFF;
            tick(); idle(); #1;
            e = b[7:0] & 8'hDF;
            chk("R2 boot load", bus_rdata, e);
            chk("R5 reserved zero", bus_rdata & 8'h20, 8'h00);
            nlock = e[7]; doff = e[6]; mlock = e[4];
            wblk  = nlock | (e[3] & e[2] & e[1]);
            // R6 R8 R9 combinational gating
            nvm_rd_req = 1; mtp_rd_req = 1; dbg_req = 1; #1;
            chk("R6 nvm rd_en", {7'd0, nvm_rd_en}, {7'd0, ~nlock});
            chk("R6 nvm rdata", nvm_rdata, nlock ? 8'h00 : 8'hA5);
            chk("R7 wp ignores reads", {7'd0, nvm_rd_en}, {7'd0, ~nlock});
            chk("R8 mtp rd_en", {7'd0, mtp_rd_en}, {7'd0, ~mlock});
            chk("R8 mtp rdata", mtp_rdata, mlock ? 8'h00 : 8'h5A);
            chk("R9 dbg grant", {7'd0, dbg_grant}, {7'd0, ~doff});
            idle();
            // R7 R10 NVM write
            nvm_wr_req = 1; #1;
            chk("R7 nvm wr_en", {7'd0, nvm_wr_en}, {7'd0, ~wblk});
            tick(); idle(); #1;
            chk("R10 nvm err rise", {7'd0, nvm_err}, {7'd0, wblk});
            tick();
            chk("R10 nvm err one cycle", {7'd0, nvm_err}, 8'h00);
            // R8 R10 MTP write
            mtp_wr_req = 1; #1;
            chk("R8 mtp wr_en", {7'd0, mtp_wr_en}, {7'd0, ~mlock});
            tick(); idle(); #1;
            chk("R10 mtp err rise", {7'd0, mtp_err}, {7'd0, mlock});
            tick();
            chk("R10 mtp err one cycle", {7'd0, mtp_err}, 8'h00);
            // R3 other address write ignored, R11 other address reads zero
            bus_wr = 1; bus_addr = 8'hDB; bus_wdata = 8'hFF; #1;
            chk("R11 other addr read", bus_rdata, 8'h00);
            tick(); idle(); #1;
            chk("R3 other addr write", bus_rdata, e);
            // R4 set-only write
            w = 8'((b * 37 + 11) & 255);
            bus_wr = 1; bus_wdata = w; tick(); idle(); #1;
            e = e | (w & 8'hDF);
            chk("R4 set-only write", bus_rdata, e);
            bus_wr = 1; bus_wdata = 8'h00; tick(); idle(); #1;
            chk("R4 zero write keeps bits", bus_rdata, e);
            // R2 later boot strobe ignored
            boot_vld = 1; boot_word = 8'h00; tick(); idle(); #1;
            chk("R2 second boot ignored", bus_rdata, e);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule